// File: doc/BRIEF.md
# Binary XNOR-Popcount Neuron Unit

This block evaluates one neuron of a binarized fully-connected layer. Each input transfer carries a packed activation vector, a packed weight vector of the same length, and an unsigned fixed-point layer scale. Every element stands for +1 (bit 1) or -1 (bit 0). The elementwise product of two such values is the XNOR of their bits. A population count of the XNOR results gives the number of agreeing positions, and the signed dot product follows as twice that count minus the vector length.

The signed dot is then multiplied by the layer scale and kept at full product width without rounding. The unit also emits the binarized activation for the next layer, taken from the unscaled dot by the sign rule. The pipeline has four register stages: two for the counting tree, one for the dot conversion and one for the scale multiply. A valid/ready handshake sits on each side. Each accepted vector yields exactly one result, in order. When the consumer withholds ready while a result is waiting, the whole pipeline stops.

Top module: `bnn_neuron_unit`

## Requirements
- R1: With bit 1 meaning +1 and bit 0 meaning -1, `out_dot` equals the sum over all N positions of act times wgt, which is 2·(number of positions where the bits agree) − N, in two's complement on DOT_W = clog2(N+1)+1 bits.
- R2: When every activation bit equals its weight bit, `out_dot` is +N and `out_bit` is 1.
- R3: When every activation bit differs from its weight bit, `out_dot` is −N and `out_bit` is 0.
- R4: When exactly N/2 positions agree (N even), `out_dot` is 0 and `out_bit` is 1.
- R5: `out_scaled` equals `out_dot` times the unsigned `in_alpha` that travelled with the same vector, in two's complement on DOT_W+ALPHA_W bits, exact for alpha 0 and for alpha at its maximum.
- R6: `out_bit` is 1 exactly when the dot of the same result is greater than or equal to zero.
- R7: With `out_ready` held high and the pipeline empty, a vector accepted on one rising edge shows `out_valid` high after the fourth rising edge counted from and including the acceptance edge, and not earlier.
- R8: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the output data stays unchanged; every accepted vector produces exactly one result, in acceptance order.
- R9: Synchronous active-high `rst` clears every valid flag, so `out_valid` is low in the cycle after a reset edge and any result in flight is discarded.
- R10: With `in_valid` low, changes on `in_act`, `in_wgt` and `in_alpha` produce no output transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input vector present |
| in_ready | output | 1 | Unit accepts a vector this cycle |
| in_act | input | N | Packed binarized activations, bit 1 = +1 |
| in_wgt | input | N | Packed binarized weights, bit 1 = +1 |
| in_alpha | input | ALPHA_W | Unsigned layer scale for this vector |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_dot | output | DOT_W | Signed binary dot product |
| out_scaled | output | DOT_W+ALPHA_W | Signed dot times alpha, full width |
| out_bit | output | 1 | Sign-binarized activation for the next layer |

## Verification
The bench drives vectors whose agreement count lies at +N, −N, exactly zero and one step off full agreement. A converter that mixes up the bit encoding, or is off by one in the count-to-dot step, reports a wrong magnitude or a sign flip on these vectors. A sign rule that uses strict greater-than would output 0 on the balanced case. The scale is tried at 0 and at 255 with both polarities of dot; a multiply that treats the dot as unsigned or cuts the product width shows as a huge positive or wrapped value. A random backpressure phase and a reset with a result in flight show whether a stall drops, duplicates or corrupts a result, and whether reset leaves a stale result behind.

// File: rtl/bnn_pkg.sv
package bnn_pkg;

    // Bits needed to hold a count from 0 to n inclusive.
    function automatic int count_width(input int n);
        return $clog2(n + 1);
    endfunction

    // Number of groups needed to cover n bits in slices of g bits.
    function automatic int group_count(input int n, input int g);
        return (n + g - 1) / g;
    endfunction

endpackage

// File: rtl/bnn_group_popcount.sv
module bnn_group_popcount #(
    parameter int GROUP_W = 16,
    localparam int GC_W   = bnn_pkg::count_width(GROUP_W)
) (
    input  logic [GROUP_W-1:0] act,
    input  logic [GROUP_W-1:0] wgt,
    output logic [GC_W-1:0]    agree_cnt
);

    logic [GROUP_W-1:0] agree;

    always_comb begin
        // Binary product: 1 where the two bits agree.
        agree     = ~(act ^ wgt);
        agree_cnt = '0;
        for (int i = 0; i < GROUP_W; i++) begin
            agree_cnt = agree_cnt + GC_W'(agree[i]);
        end
    end

endmodule

// File: rtl/bnn_count_sum.sv
module bnn_count_sum #(
    parameter int NUM_G = 4,
    parameter int GC_W  = 5,
    parameter int CNT_W = 7
) (
    input  logic [NUM_G*GC_W-1:0] group_cnts,
    output logic [CNT_W-1:0]      total
);

    always_comb begin
        total = '0;
        for (int g = 0; g < NUM_G; g++) begin
            total = total + CNT_W'(group_cnts[g*GC_W +: GC_W]);
        end
    end

endmodule

// File: rtl/bnn_dot_sign.sv
module bnn_dot_sign #(
    parameter int N     = 64,
    parameter int CNT_W = 7,
    localparam int DOT_W = CNT_W + 1
) (
    input  logic [CNT_W-1:0] agree_total,
    output logic [DOT_W-1:0] dot,
    output logic             sign_bit
);

    always_comb begin
        // 2*count - N, modulo 2^DOT_W, exact because |dot| <= N < 2^(DOT_W-1).
        dot      = {agree_total, 1'b0} - DOT_W'(N);
        // Sign rule: zero maps to +1.
        sign_bit = ~dot[DOT_W-1];
    end

endmodule

// File: rtl/bnn_scale_mul.sv
module bnn_scale_mul #(
    parameter int DOT_W   = 8,
    parameter int ALPHA_W = 8,
    localparam int PROD_W = DOT_W + ALPHA_W
) (
    input  logic [DOT_W-1:0]   dot,
    input  logic [ALPHA_W-1:0] alpha,
    output logic [PROD_W-1:0]  prod
);

    logic [PROD_W-1:0] dot_ext;
    logic [PROD_W-1:0] alpha_ext;

    always_comb begin
        // Sign-extend the dot, zero-extend the scale; the low PROD_W bits of
        // the product are the exact two's complement result.
        dot_ext   = {{ALPHA_W{dot[DOT_W-1]}}, dot};
        alpha_ext = {{DOT_W{1'b0}}, alpha};
        prod      = dot_ext * alpha_ext;
    end

endmodule

// File: rtl/bnn_neuron_unit.sv
module bnn_neuron_unit #(
    parameter int N       = 64,
    parameter int ALPHA_W = 8,
    parameter int GROUP_W = 16,
    localparam int CNT_W  = bnn_pkg::count_width(N),
    localparam int DOT_W  = CNT_W + 1,
    localparam int PROD_W = DOT_W + ALPHA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [N-1:0]       in_act,
    input  logic [N-1:0]       in_wgt,
    input  logic [ALPHA_W-1:0] in_alpha,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [DOT_W-1:0]   out_dot,
    output logic [PROD_W-1:0]  out_scaled,
    output logic               out_bit
);

    localparam int NUM_G = bnn_pkg::group_count(N, GROUP_W);
    localparam int GC_W  = bnn_pkg::count_width(GROUP_W);
    localparam int PAD_N = NUM_G * GROUP_W;

    typedef struct packed {
        logic                    v;
        logic [ALPHA_W-1:0]      alpha;
        logic [NUM_G*GC_W-1:0]   cnts;
    } st_grp_t;

    typedef struct packed {
        logic                    v;
        logic [ALPHA_W-1:0]      alpha;
        logic [CNT_W-1:0]        cnt;
    } st_sum_t;

    typedef struct packed {
        logic                    v;
        logic [ALPHA_W-1:0]      alpha;
        logic [DOT_W-1:0]        dot;
        logic                    sgn;
    } st_dot_t;

    typedef struct packed {
        logic                    v;
        logic [DOT_W-1:0]        dot;
        logic [PROD_W-1:0]       prod;
        logic                    sgn;
    } st_out_t;

    typedef struct packed {
        st_grp_t s1;
        st_sum_t s2;
        st_dot_t s3;
        st_out_t s4;
    } pipe_t;

    pipe_t pipe_d;
    pipe_t pipe_q;

    logic [PAD_N-1:0]      act_pad;
    logic [PAD_N-1:0]      wgt_pad;
    logic [NUM_G*GC_W-1:0] grp_cnt;
    logic [CNT_W-1:0]      sum_cnt;
    logic [DOT_W-1:0]      dot_val;
    logic                  dot_sgn;
    logic [PROD_W-1:0]     prod_val;
    logic                  advance;

    // Pad a partial last group with act=0, wgt=1 so padding never agrees.
    if (PAD_N > N) begin : g_pad
        assign act_pad = {{(PAD_N-N){1'b0}}, in_act};
        assign wgt_pad = {{(PAD_N-N){1'b1}}, in_wgt};
    end else begin : g_nopad
        assign act_pad = in_act;
        assign wgt_pad = in_wgt;
    end

    for (genvar g = 0; g < NUM_G; g++) begin : g_grp
        bnn_group_popcount #(
            .GROUP_W (GROUP_W)
        ) u_grp (
            .act       (act_pad[g*GROUP_W +: GROUP_W]),
            .wgt       (wgt_pad[g*GROUP_W +: GROUP_W]),
            .agree_cnt (grp_cnt[g*GC_W +: GC_W])
        );
    end

    bnn_count_sum #(
        .NUM_G (NUM_G),
        .GC_W  (GC_W),
        .CNT_W (CNT_W)
    ) u_sum (
        .group_cnts (pipe_q.s1.cnts),
        .total      (sum_cnt)
    );

    bnn_dot_sign #(
        .N     (N),
        .CNT_W (CNT_W)
    ) u_dot (
        .agree_total (pipe_q.s2.cnt),
        .dot         (dot_val),
        .sign_bit    (dot_sgn)
    );

    bnn_scale_mul #(
        .DOT_W   (DOT_W),
        .ALPHA_W (ALPHA_W)
    ) u_mul (
        .dot   (pipe_q.s3.dot),
        .alpha (pipe_q.s3.alpha),
        .prod  (prod_val)
    );

    // Whole pipeline moves unless a finished result is being held.
    assign advance = ~(pipe_q.s4.v & ~out_ready);

    always_comb begin
        pipe_d = pipe_q;
        if (advance) begin
            pipe_d.s1.v     = in_valid;
            pipe_d.s1.alpha = in_alpha;
            pipe_d.s1.cnts  = grp_cnt;

            pipe_d.s2.v     = pipe_q.s1.v;
            pipe_d.s2.alpha = pipe_q.s1.alpha;
            pipe_d.s2.cnt   = sum_cnt;

            pipe_d.s3.v     = pipe_q.s2.v;
            pipe_d.s3.alpha = pipe_q.s2.alpha;
            pipe_d.s3.dot   = dot_val;
            pipe_d.s3.sgn   = dot_sgn;

            pipe_d.s4.v     = pipe_q.s3.v;
            pipe_d.s4.dot   = pipe_q.s3.dot;
            pipe_d.s4.prod  = prod_val;
            pipe_d.s4.sgn   = pipe_q.s3.sgn;
        end
        if (rst) begin
            pipe_d.s1.v = 1'b0;
            pipe_d.s2.v = 1'b0;
            pipe_d.s3.v = 1'b0;
            pipe_d.s4.v = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        pipe_q <= pipe_d;
    end

    assign in_ready   = advance;
    assign out_valid  = pipe_q.s4.v;
    assign out_dot    = pipe_q.s4.dot;
    assign out_scaled = pipe_q.s4.prod;
    assign out_bit    = pipe_q.s4.sgn;

endmodule

// File: rtl/bnn_neuron_unit_chk.sv
module bnn_neuron_unit_chk #(
    parameter int N      = 64,
    parameter int DOT_W  = 8,
    parameter int PROD_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DOT_W-1:0]  out_dot,
    input logic [PROD_W-1:0] out_scaled,
    input logic              out_bit
);

    logic [3:0] in_flight;

    always_ff @(posedge clk) begin
        if (rst) begin
            in_flight <= '0;
        end else begin
            in_flight <= in_flight + 4'(in_valid & in_ready) - 4'(out_valid & out_ready);
        end
    end

    AST_DOT_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($signed(out_dot) <= N && $signed(out_dot) >= -N
                       && out_dot[0] == 1'(N % 2))); // R1

    AST_SIGN_RULE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_bit == ~out_dot[DOT_W-1])); // R6

    AST_SCALE_SIGN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_scaled != '0) |-> (out_scaled[PROD_W-1] == out_dot[DOT_W-1])); // R5

    AST_SCALE_ZERO: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_dot == '0) |-> (out_scaled == '0)); // R5

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_dot)
                                       && $stable(out_scaled) && $stable(out_bit))); // R8

    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !in_ready); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> !out_valid); // R9

    AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (in_flight != '0)); // R10

endmodule

bind bnn_neuron_unit bnn_neuron_unit_chk #(
    .N      (N),
    .DOT_W  (DOT_W),
    .PROD_W (PROD_W)
) chk_i (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_dot    (out_dot),
    .out_scaled (out_scaled),
    .out_bit    (out_bit)
);

// File: tb/bnn_neuron_unit_tb_top.sv
module bnn_neuron_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N       = 64;
    localparam int ALPHA_W = 8;
    localparam int DOT_W   = 8;
    localparam int PROD_W  = 16;

    typedef struct packed {
        logic [63:0] a;
        logic [63:0] w;
        logic [7:0]  al;
        int          dot;
        int          sc;
        int          tag;
    } vec_t;

    // tag 2 = R2, 3 = R3, 4 = R4, 5 = R5, 1 = R1
    localparam vec_t TBL [10] = '{
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd1,   64,  64,     2},
        '{64'h0,                   64'h0,                   8'd255, 64,  16320,  2},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0,                   8'd200, -64, -12800, 3},
        '{64'hAAAA_AAAA_AAAA_AAAA, 64'h5555_5555_5555_5555, 8'd255, -64, -16320, 3},
        '{64'hFFFF_FFFF_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF, 8'd77,  0,   0,      4},
        '{64'h5555_5555_5555_5555, 64'h0,                   8'd255, 0,   0,      4},
        '{64'h1,                   64'h0,                   8'd3,   62,  186,    1},
        '{64'hFF,                  64'h0,                   8'd10,  48,  480,    1},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 8'd0,   64,  0,      5},
        '{64'h7,                   64'h0,                   8'd128, 58,  7424,   5}
    };

    logic               clk = 1'b0;
    logic               rst;
    logic               in_valid;
    logic               in_ready;
    logic [N-1:0]       in_act;
    logic [N-1:0]       in_wgt;
    logic [ALPHA_W-1:0] in_alpha;
    logic               out_valid;
    logic               out_ready;
    logic [DOT_W-1:0]   out_dot;
    logic [PROD_W-1:0]  out_scaled;
    logic               out_bit;

    int errors = 0;
    int checks = 0;
    int sent = 0;
    int received = 0;
    bit stall_mode = 0;
    bit done = 0;
    int exp_dot [$];
    int exp_sc [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bnn_neuron_unit #(
        .N       (N),
        .ALPHA_W (ALPHA_W),
        .GROUP_W (16)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_act     (in_act),
        .in_wgt     (in_wgt),
        .in_alpha   (in_alpha),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_dot    (out_dot),
        .out_scaled (out_scaled),
        .out_bit    (out_bit)
    );

    function automatic int model_dot(input logic [N-1:0] a, input logic [N-1:0] w);
        int s = 0;
        for (int i = 0; i < N; i++) begin
            s += ((a[i] ? 1 : -1) * (w[i] ? 1 : -1));
        end
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one vector and wait until it is accepted.
    task automatic send(input logic [N-1:0] a, input logic [N-1:0] w, input logic [ALPHA_W-1:0] al);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_act   = a;
        in_wgt   = w;
        in_alpha = al;
        forever begin
            @(negedge clk);
            if (in_ready) begin
                exp_dot.push_back(model_dot(a, w));
                exp_sc.push_back(model_dot(a, w) * int'(al));
                sent++;
                break;
            end
        end
        @(posedge clk); #1;
        in_valid = 1'b0;
    endtask

    // Scoreboard: compares every transfer against the model (R1, R5, R6, R8).
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_dot.size() == 0) begin
                check(1'b0, "R8 unexpected result", int'($signed(out_dot)), 0);
            end else begin
                int ed;
                int es;
                ed = exp_dot.pop_front();
                es = exp_sc.pop_front();
                check(int'($signed(out_dot)) == ed, "R1 dot", int'($signed(out_dot)), ed);
                check(int'($signed(out_scaled)) == es, "R5 scaled", int'($signed(out_scaled)), es);
                check(out_bit == (ed >= 0), "R6 sign bit", int'(out_bit), int'(ed >= 0));
            end
            received++;
        end
    end

    // Random backpressure during the stall phase.
    initial begin
        forever begin
            @(posedge clk); #1;
            if (stall_mode) out_ready = 1'($urandom % 2);
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [DOT_W-1:0]  held_dot;
        logic [PROD_W-1:0] held_sc;
        rst       = 1'b1;
        in_valid  = 1'b0;
        in_act    = '0;
        in_wgt    = '0;
        in_alpha  = '0;
        out_ready = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R9 reset state", int'(out_valid), 0);
        @(posedge clk); #1;
        rst = 1'b0;

        // Table walk: R1..R6 directed vectors.
        foreach (TBL[k]) begin
            int wait_n;
            send(TBL[k].a, TBL[k].w, TBL[k].al);
            wait_n = 0;
            while (!out_valid && wait_n < 10) begin
                @(negedge clk);
                wait_n++;
            end
            check(int'($signed(out_dot)) == TBL[k].dot,
                  $sformatf("R%0d table dot %0d", TBL[k].tag, k), int'($signed(out_dot)), TBL[k].dot);
            check(int'($signed(out_scaled)) == TBL[k].sc,
                  $sformatf("R%0d table scaled %0d", TBL[k].tag, k), int'($signed(out_scaled)), TBL[k].sc);
            check(out_bit == (TBL[k].dot >= 0),
                  $sformatf("R%0d table bit %0d", TBL[k].tag, k), int'(out_bit), int'(TBL[k].dot >= 0));
            @(negedge clk);
        end

        // R7: latency from the acceptance edge, pipeline empty.
        send({$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom));
        // send returned #1 after the acceptance edge; next negedges follow E0..E3
        for (int c = 1; c <= 3; c++) begin
            @(negedge clk);
            check(out_valid == 1'b0, $sformatf("R7 early valid after edge %0d", c), int'(out_valid), 0);
        end
        @(negedge clk);
        check(out_valid == 1'b1, "R7 valid after fourth edge", int'(out_valid), 1);
        repeat (3) @(negedge clk);

        // R8: random vectors with random backpressure.
        stall_mode = 1'b1;
        for (int j = 0; j < 60; j++) begin
            send({$urandom, $urandom}, {$urandom, $urandom}, 8'($urandom));
        end
        stall_mode = 1'b0;
        @(posedge clk); #1;
        out_ready = 1'b1;
        repeat (12) @(negedge clk);
        check(exp_dot.size() == 0, "R8 results missing", exp_dot.size(), 0);
        check(received == sent, "R8 result count", received, sent);

        // R8 hold and R9 reset with a result in flight.
        out_ready = 1'b0;
        send(64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 8'd9);
        repeat (6) @(negedge clk);
        check(out_valid == 1'b1, "R8 result waiting", int'(out_valid), 1);
        check(in_ready == 1'b0, "R8 in_ready while held", int'(in_ready), 0);
        held_dot = out_dot;
        held_sc  = out_scaled;
        repeat (3) @(negedge clk);
        check(out_dot == held_dot, "R8 held dot", int'($signed(out_dot)), int'($signed(held_dot)));
        check(out_scaled == held_sc, "R8 held scaled", int'($signed(out_scaled)), int'($signed(held_sc)));
        @(posedge clk); #1;
        rst = 1'b1;
        exp_dot.delete();
        exp_sc.delete();
        sent = 0;
        received = 0;
        @(posedge clk); #1;
        rst = 1'b0;
        out_ready = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R9 valid cleared", int'(out_valid), 0);

        // R10: changing data with in_valid low yields nothing.
        for (int j = 0; j < 8; j++) begin
            @(posedge clk); #1;
            in_act   = {$urandom, $urandom};
            in_wgt   = {$urandom, $urandom};
            in_alpha = 8'($urandom);
            @(negedge clk);
            check(out_valid == 1'b0, "R10 idle output", int'(out_valid), 0);
        end
        check(received == 0, "R10 no transfers", received, 0);

        done = 1'b1;
        finish_run();
    end

endmodule